// File: doc/BRIEF.md
# MHz Readout Corrector

This block drives the MHz digits of a frequency readout whose kHz digits come from a separate up/down counter. Every gate period it gets four things: the kHz counter's carry and borrow pulses from its top digit, a parallel BCD MHz value from the active front end, and a two-bit source mode. On the latch strobe that also freezes the kHz digits, it registers a corrected MHz value, an extra overflow digit, two blank controls and an over-range flag. All displayed digits therefore belong to the same measurement.

With the interpolating front end, a carry means the kHz count went above its 1 MHz span, so the MHz value shown is one higher than the input. A borrow means it went below the span, so the value shown is one lower. With the low-frequency adapter the MHz digits read 00 and are blanked, unless the count went above 1 MHz. In external-input mode the parallel input is ignored and the kHz carries are counted into a BCD MHz count that can spill into a further digit. In BFO-read mode the MHz readout is blanked.

Top module: `mhz_readout`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state of the outputs is: `mhz_out` 00, `ovf_out` 0, `blank_mhz` 1, `blank_ovf` 1, `over_range` 0.
- R2: The outputs change only on the edge where `latch_strobe` is high, and take their new value in the cycle that follows. A change of `mhz_in` or `mode` while `latch_strobe` is low has no effect on them. `mode` encodings: 00 parallel front end, 01 low-frequency adapter, 10 external input, 11 BFO read. `mhz_in[7:4]` is the tens digit and `mhz_in[3:0]` the units digit.
- R3: In parallel mode the latched `mhz_out` is `mhz_in` plus the net correction. The net correction is the count of carries minus the count of borrows since the last gate start, held to the range -1..+1 (a carry after a borrow cancels it). `blank_mhz` is 0.
- R4: In parallel mode, a -1 correction of 00 gives 99 with `over_range` 1. A +1 correction of 99 gives 00 with `ovf_out` 1 and `over_range` 1. Otherwise `ovf_out` is 0 and `over_range` is 0.
- R5: In low-frequency mode, a net +1 correction gives `mhz_out` 01, `blank_mhz` 0 and `over_range` 1. Any other correction gives `mhz_out` 00, `blank_mhz` 1 and `over_range` 0.
- R6: In external mode `mhz_in` and borrows are ignored. `mhz_out` shows, in BCD, the carries counted since the last gate start, modulo 100.
- R7: In external mode a count passing 99 increments `ovf_out`, up to OVF_MAX (default 1, giving readings up to 199). Passing OVF_MAX·100+99 wraps the count to 0 and sets `over_range` until the next gate start.
- R8: In BFO-read mode `mhz_out` is 00, `blank_mhz` is 1 and `over_range` is 0.
- R9: `gate_start` clears the correction and the external count. A carry or borrow in the same cycle as `gate_start` counts toward the new gate. A `latch_strobe` in the same cycle as `gate_start` latches the old gate's state. Events in the strobe cycle count toward the following latch.
- R10: `blank_ovf` is 1 exactly when the latched `ovf_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Source mode (00 parallel, 01 LF, 10 external, 11 BFO read) |
| mhz_in | input | 8 | Parallel BCD MHz value, tens in the upper nibble |
| khz_carry | input | 1 | One-cycle pulse: kHz count passed its top |
| khz_borrow | input | 1 | One-cycle pulse: kHz count passed below zero |
| gate_start | input | 1 | One-cycle pulse: a new gate period begins |
| latch_strobe | input | 1 | One-cycle pulse: latch the readout |
| mhz_out | output | 8 | Latched BCD MHz digits, tens in the upper nibble |
| ovf_out | output | 1 | Latched extra overflow digit (binary) |
| blank_mhz | output | 1 | Blank the MHz digits |
| blank_ovf | output | 1 | Blank the overflow digit |
| over_range | output | 1 | Over-range warning |

## Verification
Every result appears in the cycle after the edge that samples `latch_strobe`, and no output moves at any other time. The correction state and external count take each event one edge after it is driven, and they feed the latch on the strobe edge that follows. The bench drives inputs on falling edges, updates its integer reference model on each rising edge from the values it sampled there, and compares all five outputs on the next falling edge, once per cycle. The directed checks read the outputs on the falling edge right after the strobe cycle, and again several cycles later to confirm they held.

// File: rtl/mhz_readout_pkg.sv
// Package: shared encodings for the MHz readout corrector.
// Assumes: mode codes are fixed by the panel wiring and never change.
package mhz_readout_pkg;

    // Source of the MHz digits.
    typedef enum logic [1:0] {
        SRC_PARALLEL = 2'b00,
        SRC_LF       = 2'b01,
        SRC_EXT      = 2'b10,
        SRC_BFO      = 2'b11
    } src_mode_e;

    // Net readout correction collected over one gate.
    typedef enum logic [1:0] {
        CORR_NONE = 2'b00,
        CORR_UP   = 2'b01,
        CORR_DOWN = 2'b10
    } corr_e;

endpackage

// File: rtl/mhz_bcd_step.sv
// Module: mhz_bcd_step
// Adds +1 or -1 to a multi-digit BCD value, wrapping each digit in BCD.
// It reports when the carry or borrow ripples out of the top digit.
// Assumes: up and down are never high together, and every input digit
// is valid BCD (0..9). Purely combinational.
module mhz_bcd_step #(
    parameter int DIGITS = 2,
    localparam int W = 4 * DIGITS
) (
    input  logic [W-1:0] val,
    input  logic         up,
    input  logic         down,
    output logic [W-1:0] res,
    output logic         wrap
);

    // Digit-serial ripple of the increment or decrement.
    always_comb begin
        logic       ci;
        logic       bi;
        logic [3:0] d;
        ci  = up;
        bi  = down;
        res = '0;
        for (int i = 0; i < DIGITS; i++) begin
            d = val[4*i +: 4];
            if (ci)
                res[4*i +: 4] = (d == 4'd9) ? 4'd0 : d + 4'd1;
            else if (bi)
                res[4*i +: 4] = (d == 4'd0) ? 4'd9 : d - 4'd1;
            else
                res[4*i +: 4] = d;
            ci = ci && (d == 4'd9);
            bi = bi && (d == 4'd0);
        end
        wrap = ci || bi;
    end

endmodule

// File: rtl/mhz_corr_track.sv
// Module: mhz_corr_track
// Tracks the net carry/borrow of the kHz counter's top digit over one
// gate, held to -1, 0 or +1. A gate start clears the state, and events
// in the same cycle apply to the new gate.
// Assumes: carry and borrow are single-cycle pulses.
module mhz_corr_track
    import mhz_readout_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  gate_start,
    input  logic  carry,
    input  logic  borrow,
    output corr_e corr
);

    corr_e corr_q;
    corr_e base;
    corr_e corr_d;

    // Next correction: clear on gate start, then apply this cycle's event.
    always_comb begin
        base   = gate_start ? CORR_NONE : corr_q;
        corr_d = base;
        if (carry && !borrow)
            corr_d = (base == CORR_DOWN) ? CORR_NONE : CORR_UP;
        else if (borrow && !carry)
            corr_d = (base == CORR_UP) ? CORR_NONE : CORR_DOWN;
    end

    // Correction register, synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) corr_q <= CORR_NONE;
        else        corr_q <= corr_d;
    end

    assign corr = corr_q;

    // R9: a quiet gate start leaves no correction behind.
    a_r9_gate_clears_corr: assert property (@(posedge clk) disable iff (!rst_n)
        gate_start && !carry && !borrow |=> corr_q == CORR_NONE);

    // R3: a lone carry never leaves a downward correction.
    a_r3_carry_not_down: assert property (@(posedge clk) disable iff (!rst_n)
        carry && !borrow |=> corr_q != CORR_DOWN);

    // R3: a lone borrow never leaves an upward correction.
    a_r3_borrow_not_up: assert property (@(posedge clk) disable iff (!rst_n)
        borrow && !carry |=> corr_q != CORR_UP);

endmodule

// File: rtl/mhz_ext_count.sv
// Module: mhz_ext_count
// Counts kHz-overflow carries into a BCD MHz value. The count spills
// into a binary extra digit that runs 0..OVF_MAX, and past that the
// count wraps and a sticky over-range flag is set. A gate start clears
// everything, and an increment in the same cycle applies to the new gate.
// Assumes: inc is a single-cycle pulse and OVF_MAX >= 1.
module mhz_ext_count #(
    parameter int DIGITS  = 2,
    parameter int OVF_MAX = 1,
    localparam int W      = 4 * DIGITS,
    localparam int OVF_W  = (OVF_MAX < 2) ? 1 : $clog2(OVF_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_start,
    input  logic             inc,
    output logic [W-1:0]     cnt_bcd,
    output logic [OVF_W-1:0] cnt_ovf,
    output logic             cnt_over
);

    logic [W-1:0]     lo_q;
    logic [OVF_W-1:0] ovf_q;
    logic             over_q;
    logic [W-1:0]     base_lo;
    logic [OVF_W-1:0] base_ovf;
    logic             base_over;
    logic [W-1:0]     step_lo;
    logic             step_wrap;

    // Start-of-gate view of the count.
    always_comb begin
        base_lo   = gate_start ? '0   : lo_q;
        base_ovf  = gate_start ? '0   : ovf_q;
        base_over = gate_start ? 1'b0 : over_q;
    end

    mhz_bcd_step #(.DIGITS(DIGITS)) u_step (
        .val  (base_lo),
        .up   (inc),
        .down (1'b0),
        .res  (step_lo),
        .wrap (step_wrap)
    );

    // Count registers: low digits, extra digit and sticky over-range.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q   <= '0;
            ovf_q  <= '0;
            over_q <= 1'b0;
        end else begin
            lo_q <= step_lo;
            if (step_wrap && base_ovf == OVF_W'(OVF_MAX)) begin
                ovf_q  <= '0;
                over_q <= 1'b1;
            end else if (step_wrap) begin
                ovf_q  <= OVF_W'(base_ovf + 1'b1);
                over_q <= base_over;
            end else begin
                ovf_q  <= base_ovf;
                over_q <= base_over;
            end
        end
    end

    assign cnt_bcd  = lo_q;
    assign cnt_ovf  = ovf_q;
    assign cnt_over = over_q;

    // R9: a quiet gate start empties the count.
    a_r9_ext_clear: assert property (@(posedge clk) disable iff (!rst_n)
        gate_start && !inc |=> lo_q == '0 && ovf_q == '0 && !over_q);

    // R6: without a carry or a gate start the count holds.
    a_r6_ext_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_start && !inc |=> $stable(lo_q) && $stable(ovf_q) && $stable(over_q));

    // R6: a carry with a non-9 units digit steps only the units.
    a_r6_ext_units_step: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_start && inc && lo_q[3:0] != 4'd9
        |=> lo_q[3:0] == $past(lo_q[3:0]) + 4'd1 && $stable(ovf_q));

    // R7: a carry out of the full count wraps to zero and flags over-range.
    a_r7_ext_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_start && inc && step_wrap && ovf_q == OVF_W'(OVF_MAX)
        |=> lo_q == '0 && ovf_q == '0 && over_q);

endmodule

// File: rtl/mhz_readout.sv
// Module: mhz_readout (top)
// Builds the MHz part of a frequency readout. Each gate it collects the
// kHz carry/borrow events. On the latch strobe it registers the MHz
// digits, the extra overflow digit, the blanks and the over-range flag
// for the current source mode.
// Assumes: event inputs are single-cycle pulses, mhz_in holds valid BCD,
// and the strobe arrives at the same edge that latches the kHz digits.
module mhz_readout
    import mhz_readout_pkg::*;
#(
    parameter int DIGITS  = 2,
    parameter int OVF_MAX = 1,
    localparam int W      = 4 * DIGITS,
    localparam int OVF_W  = (OVF_MAX < 2) ? 1 : $clog2(OVF_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic [W-1:0]     mhz_in,
    input  logic             khz_carry,
    input  logic             khz_borrow,
    input  logic             gate_start,
    input  logic             latch_strobe,
    output logic [W-1:0]     mhz_out,
    output logic [OVF_W-1:0] ovf_out,
    output logic             blank_mhz,
    output logic             blank_ovf,
    output logic             over_range
);

    src_mode_e        src;
    corr_e            corr;
    logic [W-1:0]     ext_bcd;
    logic [OVF_W-1:0] ext_ovf;
    logic             ext_over;
    logic [W-1:0]     adj_val;
    logic             adj_wrap;
    logic [W-1:0]     nxt_mhz;
    logic [OVF_W-1:0] nxt_ovf;
    logic             nxt_blank;
    logic             nxt_over;

    assign src = src_mode_e'(mode);

    mhz_corr_track u_corr (
        .clk        (clk),
        .rst_n      (rst_n),
        .gate_start (gate_start),
        .carry      (khz_carry),
        .borrow     (khz_borrow),
        .corr       (corr)
    );

    mhz_ext_count #(.DIGITS(DIGITS), .OVF_MAX(OVF_MAX)) u_ext (
        .clk        (clk),
        .rst_n      (rst_n),
        .gate_start (gate_start),
        .inc        (khz_carry),
        .cnt_bcd    (ext_bcd),
        .cnt_ovf    (ext_ovf),
        .cnt_over   (ext_over)
    );

    mhz_bcd_step #(.DIGITS(DIGITS)) u_adj (
        .val  (mhz_in),
        .up   (corr == CORR_UP),
        .down (corr == CORR_DOWN),
        .res  (adj_val),
        .wrap (adj_wrap)
    );

    // Select the readout for the current source mode.
    always_comb begin
        nxt_mhz   = '0;
        nxt_ovf   = '0;
        nxt_blank = 1'b1;
        nxt_over  = 1'b0;
        case (src)
            SRC_PARALLEL: begin
                nxt_mhz   = adj_val;
                nxt_ovf   = (adj_wrap && corr == CORR_UP) ? OVF_W'(1) : '0;
                nxt_blank = 1'b0;
                nxt_over  = adj_wrap;
            end
            SRC_LF: begin
                nxt_mhz   = (corr == CORR_UP) ? W'(1) : '0;
                nxt_blank = (corr != CORR_UP);
                nxt_over  = (corr == CORR_UP);
            end
            SRC_EXT: begin
                nxt_mhz   = ext_bcd;
                nxt_ovf   = ext_ovf;
                nxt_blank = 1'b0;
                nxt_over  = ext_over;
            end
            default: begin
                nxt_mhz   = '0;
                nxt_blank = 1'b1;
            end
        endcase
    end

    // Display latch, loaded only on the measurement strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mhz_out    <= '0;
            ovf_out    <= '0;
            blank_mhz  <= 1'b1;
            blank_ovf  <= 1'b1;
            over_range <= 1'b0;
        end else if (latch_strobe) begin
            mhz_out    <= nxt_mhz;
            ovf_out    <= nxt_ovf;
            blank_mhz  <= nxt_blank;
            blank_ovf  <= (nxt_ovf == '0);
            over_range <= nxt_over;
        end
    end

    // R2: outputs hold between strobes.
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_strobe |=> $stable(mhz_out) && $stable(ovf_out) && $stable(blank_mhz)
                          && $stable(blank_ovf) && $stable(over_range));

    // R8: BFO read blanks the MHz readout with no warning.
    a_r8_bfo_blank: assert property (@(posedge clk) disable iff (!rst_n)
        latch_strobe && src == SRC_BFO |=> blank_mhz && !over_range && mhz_out == '0);

    // R5: LF readout never shows tens and is blanked exactly when not over range.
    a_r5_lf_digits: assert property (@(posedge clk) disable iff (!rst_n)
        latch_strobe && src == SRC_LF |=> mhz_out[W-1:4] == '0 && (blank_mhz != over_range));

    // R10: the extra digit is blanked exactly when it reads zero.
    a_r10_ovf_blank: assert property (@(posedge clk) disable iff (!rst_n)
        blank_ovf == (ovf_out == '0));

    // R3: parallel mode never blanks the digits.
    a_r3_parallel_shown: assert property (@(posedge clk) disable iff (!rst_n)
        latch_strobe && src == SRC_PARALLEL |=> !blank_mhz);

endmodule

// File: tb/sim_mhz_readout.sv
module sim_mhz_readout;
    localparam int CLK_PERIOD = 10;
    localparam int OVF_MAX    = 1;
    localparam int FULL       = (OVF_MAX + 1) * 100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [7:0] mhz_in = 8'h00;
    logic       khz_carry = 1'b0;
    logic       khz_borrow = 1'b0;
    logic       gate_start = 1'b0;
    logic       latch_strobe = 1'b0;
    logic [7:0] mhz_out;
    logic [0:0] ovf_out;
    logic       blank_mhz;
    logic       blank_ovf;
    logic       over_range;

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_req = "R1";
    bit    finished = 1'b0;

    // Reference model state
    int m_corr = 0, m_cnt = 0, m_eor = 0;
    int e_mhz = 0, e_ovf = 0, e_bm = 1, e_bo = 1, e_or = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mhz_readout u0 (
        .clk(clk), .rst_n(rst_n), .mode(mode), .mhz_in(mhz_in),
        .khz_carry(khz_carry), .khz_borrow(khz_borrow),
        .gate_start(gate_start), .latch_strobe(latch_strobe),
        .mhz_out(mhz_out), .ovf_out(ovf_out), .blank_mhz(blank_mhz),
        .blank_ovf(blank_ovf), .over_range(over_range)
    );

    function automatic int bcd2int(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] int2bcd(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    // Behavioural reference, advanced on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_corr = 0; m_cnt = 0; m_eor = 0;
            e_mhz = 0; e_ovf = 0; e_bm = 1; e_bo = 1; e_or = 0;
        end else begin
            if (latch_strobe) begin
                int v;
                e_ovf = 0; e_or = 0;
                case (mode)
                    2'b00: begin
                        v = bcd2int(mhz_in) + m_corr; e_bm = 0;
                        if (v < 0) begin v = 99; e_or = 1; end
                        else if (v > 99) begin v = 0; e_or = 1; e_ovf = 1; end
                        e_mhz = v;
                    end
                    2'b01: begin
                        e_mhz = (m_corr == 1) ? 1 : 0;
                        e_bm  = (m_corr == 1) ? 0 : 1;
                        e_or  = (m_corr == 1) ? 1 : 0;
                    end
                    2'b10: begin
                        e_mhz = m_cnt % 100; e_ovf = m_cnt / 100;
                        e_bm = 0; e_or = m_eor;
                    end
                    default: begin e_mhz = 0; e_bm = 1; end
                endcase
                e_bo = (e_ovf == 0) ? 1 : 0;
            end
            if (gate_start) begin m_corr = 0; m_cnt = 0; m_eor = 0; end
            if (khz_carry && !khz_borrow && m_corr < 1) m_corr++;
            if (khz_borrow && !khz_carry && m_corr > -1) m_corr--;
            if (khz_carry) begin
                m_cnt++;
                if (m_cnt == FULL) begin m_cnt = 0; m_eor = 1; end
            end
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (!finished) begin
            n_tests++;
            if (bcd2int(mhz_out) != e_mhz || int'(ovf_out) != e_ovf || int'(blank_mhz) != e_bm
                || int'(blank_ovf) != e_bo || int'(over_range) != e_or) begin
                n_fail++;
                $display("FAIL %s model: got mhz=%0d ovf=%0d bm=%0d bo=%0d or=%0d exp mhz=%0d ovf=%0d bm=%0d bo=%0d or=%0d",
                         cur_req, bcd2int(mhz_out), ovf_out, blank_mhz, blank_ovf, over_range,
                         e_mhz, e_ovf, e_bm, e_bo, e_or);
            end
        end
    end

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic show(input string req, input int mhz, input int ovf, input int bm, input int orng);
        chk(req, "mhz_out", bcd2int(mhz_out), mhz);
        chk(req, "ovf_out", int'(ovf_out), ovf);
        chk(req, "blank_mhz", int'(blank_mhz), bm);
        chk(req, "blank_ovf", int'(blank_ovf), (ovf == 0) ? 1 : 0);
        chk(req, "over_range", int'(over_range), orng);
    endtask

    // One gate: start, events, strobe; returns on the edge where outputs are valid.
    task automatic measure(input logic [1:0] m, input int v, input int nc, input int nb);
        mode = m; mhz_in = int2bcd(v); gate_start = 1'b1;
        @(negedge clk); gate_start = 1'b0;
        for (int i = 0; i < nc; i++) begin khz_carry = 1'b1; @(negedge clk); khz_carry = 1'b0; end
        for (int i = 0; i < nb; i++) begin khz_borrow = 1'b1; @(negedge clk); khz_borrow = 1'b0; end
        latch_strobe = 1'b1;
        @(negedge clk); latch_strobe = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1"; show("R1", 0, 0, 1, 0);
        rst_n = 1'b1;
        @(negedge clk);

        cur_req = "R3"; measure(2'b00, 42, 0, 0); show("R3", 42, 0, 0, 0);
        measure(2'b00, 42, 1, 0); show("R3", 43, 0, 0, 0);
        measure(2'b00, 17, 0, 1); show("R3", 16, 0, 0, 0);
        measure(2'b00, 30, 3, 0); show("R3", 31, 0, 0, 0);
        measure(2'b00, 30, 1, 1); show("R3", 30, 0, 0, 0);

        cur_req = "R2";
        mhz_in = 8'h77; mode = 2'b11;
        repeat (4) @(negedge clk);
        show("R2", 30, 0, 0, 0);

        cur_req = "R4"; measure(2'b00, 0, 0, 1); show("R4", 99, 0, 0, 1);
        measure(2'b00, 99, 1, 0); show("R4", 0, 1, 0, 1);
        measure(2'b00, 9, 1, 0); show("R4", 10, 0, 0, 0);

        cur_req = "R5"; measure(2'b01, 55, 0, 0); show("R5", 0, 0, 1, 0);
        measure(2'b01, 55, 1, 0); show("R5", 1, 0, 0, 1);
        measure(2'b01, 55, 0, 1); show("R5", 0, 0, 1, 0);

        cur_req = "R6"; measure(2'b10, 77, 5, 3); show("R6", 5, 0, 0, 0);
        measure(2'b10, 12, 0, 0); show("R6", 0, 0, 0, 0);

        cur_req = "R7"; measure(2'b10, 0, 150, 0); show("R7", 50, 1, 0, 0);
        measure(2'b10, 0, FULL + 5, 0); show("R7", 5, 0, 0, 1);
        measure(2'b10, 0, 2, 0); show("R7", 2, 0, 0, 0);

        cur_req = "R8"; measure(2'b00, 88, 1, 0);
        measure(2'b11, 88, 1, 0); show("R8", 0, 0, 1, 0);

        cur_req = "R9";
        mode = 2'b00; mhz_in = int2bcd(50);
        gate_start = 1'b1; khz_carry = 1'b1;
        @(negedge clk); gate_start = 1'b0; khz_carry = 1'b0;
        latch_strobe = 1'b1; gate_start = 1'b1;
        @(negedge clk); latch_strobe = 1'b0; gate_start = 1'b0;
        show("R9", 51, 0, 0, 0);
        latch_strobe = 1'b1; khz_borrow = 1'b1;
        @(negedge clk); latch_strobe = 1'b0; khz_borrow = 1'b0;
        show("R9", 50, 0, 0, 0);
        latch_strobe = 1'b1;
        @(negedge clk); latch_strobe = 1'b0;
        show("R9", 49, 0, 0, 0);

        cur_req = "R10"; measure(2'b10, 0, 100, 0);
        chk("R10", "blank_ovf", int'(blank_ovf), 0);
        measure(2'b10, 0, 99, 0);
        chk("R10", "blank_ovf", int'(blank_ovf), 1);

        cur_req = "R1";
        rst_n = 1'b0; @(negedge clk);
        show("R1", 0, 0, 1, 0);
        rst_n = 1'b1; @(negedge clk);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule